// File: doc/BRIEF.md
# Half-Duplex Transmit Access Controller

This block decides, cycle by cycle, whether one Ethernet port may put a frame on the wire. It does not touch frame data. It watches carrier and collision from the physical layer, a duplex flag and a transmit request from the MAC. It grants the medium only after the line has been quiet for a full interframe gap. If a collision hits a granted frame in half duplex, it drives a jam. It then holds the port off for a random number of slot times, chosen by truncated binary exponential backoff. After sixteen failed attempts it gives the frame up.

The same block also protects the receive side. In half duplex with back pressure enabled, the buffer manager raises `q_alarm` when the output queue passes its threshold. A frame that starts arriving while the alarm is up is then jammed, so the remote station sees a collision and backs off. With back pressure disabled, or in full duplex, an arriving frame that finds no free buffer is marked for dropping instead. Two strap inputs are sampled while reset is held. One selects a backoff exponent capped at 4 instead of 10. The other disables back pressure.

All timing is counted in clock cycles. `BIT_CYC` clocks make one bit time. The gap, the jam and the slot are `IFG_BITS`, `JAM_BITS` and `SLOT_BITS` bit times (96, 32 and 512 by default). Below, IFG, JAM and SLOT stand for those lengths in cycles. The interface is plain control signals, not a data stream, so it has no valid/ready handshake.

Top module: `hdx_tx_access`

## Requirements
- R1: In half duplex the port may be granted only after `crs` has stayed low for at least IFG cycles. If `tx_req` is high when `crs` falls, `tx_grant` first reads 1 in the (IFG+1)-th cycle after the fall. While `crs` is high in half duplex, no grant starts.
- R2: In half duplex, a cycle with `col`=1 while `tx_grant`=1 and `tx_req`=1 does two things in the next cycle: `tx_grant` drops and `jam_en` rises. `jam_en` then stays high for exactly JAM cycles.
- R3: When a collision jam ends and fewer than 16 collisions have hit the frame, `tx_retry` pulses for one cycle, in the first cycle with `jam_en` low. The backoff wait is r·SLOT cycles, with r drawn uniformly from 0..2^k−1 and k = min(n, cap) for the n-th collision. The next grant comes max(IFG+1, r·SLOT+2) cycles after that cycle.
- R4: `strap_lim4`, sampled while `rst_n`=0, sets the cap: 1 gives cap 4 (at most 15 slots), 0 gives cap 10 (at most 1023 slots). A change to `strap_lim4` after reset has no effect.
- R5: The 16th collision on one frame ends with a one-cycle `tx_abort` pulse and no `tx_retry`, in the first cycle with `jam_en` low. The attempt count is cleared, so the next frame's first collision uses k=1.
- R6: With `full_dup`=1, `col` is ignored (the grant continues and no jam is driven), and `crs` does not defer a grant.
- R7: With `strap_bp_off`=0 at reset, `full_dup`=0, `q_alarm`=1 and the port idle, a rising `crs` drives `jam_en` from the next cycle for exactly JAM cycles, with no grant. With `q_alarm`=0 no jam is driven.
- R8: With `no_free`=1, and either `strap_bp_off`=1 or `full_dup`=1, a rising `crs` gives a one-cycle `rx_drop` pulse in the next cycle and no jam.
- R9: While `rst_n`=0, all outputs are 0.
- R10: When `tx_req` falls while granted, the next cycle ends the grant and clears the attempt count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; straps are sampled while it is low |
| strap_lim4 | input | 1 | 1 selects backoff exponent cap 4, 0 selects 10 |
| strap_bp_off | input | 1 | 1 disables receive back pressure |
| full_dup | input | 1 | 1 = full duplex, 0 = half duplex |
| crs | input | 1 | Carrier sense, active high |
| col | input | 1 | Collision detect, active high |
| tx_req | input | 1 | MAC holds high while it has a frame to send |
| q_alarm | input | 1 | Output queue usage has reached its threshold |
| no_free | input | 1 | No free receive buffer |
| tx_grant | output | 1 | Port may transmit |
| jam_en | output | 1 | Drive the jam pattern |
| tx_retry | output | 1 | One-cycle pulse: frame will be retried after backoff |
| tx_abort | output | 1 | One-cycle pulse: frame given up after 16 collisions |
| rx_drop | output | 1 | One-cycle pulse: incoming frame must be dropped |

## Verification
The hidden state here is the gap counter, the jam counter, the attempt count and the backoff wait. Each one shows up at the ports within one frame time. A gap counter that is off by one moves the first grant after carrier falls by exactly one cycle. A wrong jam counter changes the width of `jam_en`. An attempt count that is not cleared, or a cap that is not applied, pushes the retry gap past its bound, or brings `tx_abort` at the wrong collision. The event order of grants, jams, retries, aborts and drops is also scored against a predicted list. A missing or extra pulse is therefore caught at the cycle it appears.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_XMIT  = 3'd1,
    ST_JAM   = 3'd2,
    ST_BOFF  = 3'd3,
    ST_BPJAM = 3'd4
  } hdx_state_e;
endpackage

// File: rtl/hdx_lfsr.sv
// Free-running 16-bit maximal-length LFSR; low bits are the random draw.
module hdx_lfsr #(
  parameter int W     = 16,
  parameter int OUT_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  output logic [OUT_W-1:0] rnd
);
  logic [W-1:0] sr;
  logic         fb;

  assign fb  = sr[W-1] ^ sr[W-3] ^ sr[W-4] ^ sr[W-6];
  assign rnd = sr[OUT_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sr <= W'(16'hACE1);
    else        sr <= {sr[W-2:0], fb};
  end
endmodule

// File: rtl/hdx_gap_timer.sv
// Counts consecutive quiet cycles; gap_ok once IFG_CYC have passed.
module hdx_gap_timer #(
  parameter int IFG_CYC = 96
) (
  input  logic clk,
  input  logic rst_n,
  input  logic busy,
  output logic gap_ok
);
  localparam int CW = $clog2(IFG_CYC + 1);
  logic [CW-1:0] quiet;

  assign gap_ok = (quiet == CW'(IFG_CYC));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       quiet <= '0;
    else if (busy)    quiet <= '0;
    else if (!gap_ok) quiet <= quiet + 1'b1;
  end
endmodule

// File: rtl/hdx_backoff.sv
// Truncated binary exponential backoff: masks the random draw to k bits,
// k = min(attempts, cap), and counts the resulting wait in cycles.
module hdx_backoff #(
  parameter int SLOT_CYC = 512,
  parameter int RND_W    = 10,
  parameter int AW       = 5,
  parameter int STD_CAP  = 10,
  parameter int LIM_CAP  = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [AW-1:0]    attempts,
  input  logic             lim4,
  input  logic [RND_W-1:0] rnd,
  output logic             done
);
  localparam int WAIT_W = RND_W + $clog2(SLOT_CYC + 1);

  logic [RND_W-1:0]  mask;
  logic [WAIT_W-1:0] boff_len;
  logic [WAIT_W-1:0] left;

  for (genvar i = 0; i < RND_W; i++) begin : g_mask
    assign mask[i] = (AW'(i) < attempts) && (i < (lim4 ? LIM_CAP : STD_CAP));
  end

  assign boff_len = WAIT_W'(rnd & mask) * WAIT_W'(SLOT_CYC);
  assign done     = (left == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     left <= '0;
    else if (load)  left <= boff_len;
    else if (!done) left <= left - 1'b1;
  end
endmodule

// File: rtl/hdx_tx_access.sv
module hdx_tx_access #(
  parameter int BIT_CYC     = 1,
  parameter int IFG_BITS    = 96,
  parameter int JAM_BITS    = 32,
  parameter int SLOT_BITS   = 512,
  parameter int ATTEMPT_MAX = 16,
  parameter int STD_CAP     = 10,
  parameter int LIM_CAP     = 4,
  parameter int LFSR_W      = 16
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strap_lim4,
  input  logic strap_bp_off,
  input  logic full_dup,
  input  logic crs,
  input  logic col,
  input  logic tx_req,
  input  logic q_alarm,
  input  logic no_free,
  output logic tx_grant,
  output logic jam_en,
  output logic tx_retry,
  output logic tx_abort,
  output logic rx_drop
);
  import hdx_pkg::*;

  localparam int IFG_CYC  = IFG_BITS * BIT_CYC;
  localparam int JAM_CYC  = JAM_BITS * BIT_CYC;
  localparam int SLOT_CYC = SLOT_BITS * BIT_CYC;
  localparam int AW       = $clog2(ATTEMPT_MAX + 1);
  localparam int JW       = $clog2(JAM_CYC + 1);
  localparam int RND_W    = STD_CAP;

  hdx_state_e       st;
  logic [AW-1:0]    attempts;
  logic [JW-1:0]    jam_cnt;
  logic [RND_W-1:0] rnd_now, rnd_q;
  logic             crs_q, lim4_q, bp_off_q;
  logic             retry_q, abort_q, drop_q;
  logic             half, rx_start, busy, gap_ok, jam_done, boff_load, boff_done;

  // Straps are held in registers loaded only while reset is asserted.
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim4_q   <= strap_lim4;
      bp_off_q <= strap_bp_off;
    end
  end

  assign half      = !full_dup;
  assign rx_start  = crs && !crs_q;
  assign busy      = (st == ST_XMIT) || (st == ST_JAM) || (st == ST_BPJAM) || (crs && half);
  assign jam_done  = (jam_cnt == '0);
  assign boff_load = (st == ST_JAM) && jam_done && (attempts != AW'(ATTEMPT_MAX));

  hdx_lfsr #(.W(LFSR_W), .OUT_W(RND_W)) u_lfsr (
    .clk(clk), .rst_n(rst_n), .rnd(rnd_now)
  );

  hdx_gap_timer #(.IFG_CYC(IFG_CYC)) u_gap (
    .clk(clk), .rst_n(rst_n), .busy(busy), .gap_ok(gap_ok)
  );

  hdx_backoff #(
    .SLOT_CYC(SLOT_CYC), .RND_W(RND_W), .AW(AW),
    .STD_CAP(STD_CAP), .LIM_CAP(LIM_CAP)
  ) u_boff (
    .clk(clk), .rst_n(rst_n), .load(boff_load), .attempts(attempts),
    .lim4(lim4_q), .rnd(rnd_q), .done(boff_done)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      attempts <= '0;
      jam_cnt  <= '0;
      rnd_q    <= '0;
      crs_q    <= 1'b0;
      retry_q  <= 1'b0;
      abort_q  <= 1'b0;
      drop_q   <= 1'b0;
    end else begin
      crs_q   <= crs;
      retry_q <= 1'b0;
      abort_q <= 1'b0;
      drop_q  <= rx_start && no_free && (bp_off_q || full_dup);
      unique case (st)
        ST_IDLE: begin
          if (half && !bp_off_q && q_alarm && rx_start) begin
            st      <= ST_BPJAM;
            jam_cnt <= JW'(JAM_CYC - 1);
          end else if (tx_req && gap_ok && !(crs && half)) begin
            st <= ST_XMIT;
          end
        end
        ST_XMIT: begin
          if (!tx_req) begin
            st       <= ST_IDLE;
            attempts <= '0;
          end else if (half && col) begin
            st       <= ST_JAM;
            jam_cnt  <= JW'(JAM_CYC - 1);
            attempts <= attempts + 1'b1;
            rnd_q    <= rnd_now;
          end
        end
        ST_JAM: begin
          if (!jam_done) begin
            jam_cnt <= jam_cnt - 1'b1;
          end else if (attempts == AW'(ATTEMPT_MAX)) begin
            st       <= ST_IDLE;
            abort_q  <= 1'b1;
            attempts <= '0;
          end else begin
            st      <= ST_BOFF;
            retry_q <= 1'b1;
          end
        end
        ST_BOFF: if (boff_done) st <= ST_IDLE;
        ST_BPJAM: begin
          if (jam_done) st <= ST_IDLE;
          else          jam_cnt <= jam_cnt - 1'b1;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign tx_grant = (st == ST_XMIT);
  assign jam_en   = (st == ST_JAM) || (st == ST_BPJAM);
  assign tx_retry = retry_q;
  assign tx_abort = abort_q;
  assign rx_drop  = drop_q;
endmodule

// File: rtl/hdx_tx_access_chk.sv
module hdx_tx_access_chk (
  input logic clk,
  input logic rst_n,
  input logic full_dup,
  input logic crs,
  input logic col,
  input logic tx_req,
  input logic q_alarm,
  input logic tx_grant,
  input logic jam_en,
  input logic tx_retry,
  input logic tx_abort
);
  AST_GRANT_START_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_grant) |-> $past(!crs || full_dup)); // R1

  AST_COL_TO_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && tx_grant && tx_req && col) |=> (jam_en && !tx_grant)); // R2

  AST_GRANT_JAM_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(tx_grant && jam_en)); // R2

  AST_END_PULSE_AFTER_JAM: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_retry || tx_abort) |-> $past(jam_en)); // R3

  AST_RETRY_ABORT_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({tx_retry, tx_abort})); // R5

  AST_FULL_IGNORES_COL: assert property (@(posedge clk) disable iff (!rst_n)
    (full_dup && tx_grant && tx_req) |=> tx_grant); // R6

  AST_BP_NEEDS_ALARM: assert property (@(posedge clk) disable iff (!rst_n)
    (!full_dup && $rose(jam_en) && !$past(tx_grant)) |-> $past(q_alarm)); // R7
endmodule

bind hdx_tx_access hdx_tx_access_chk u_chk (.*);

// File: tb/hdx_tx_access_bench.sv
module hdx_tx_access_bench;
  localparam int IFG  = 12;
  localparam int JAM  = 4;
  localparam int SLOT = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_lim4 = 1'b0, strap_bp_off = 1'b0, full_dup = 1'b0;
  logic crs = 1'b0, col = 1'b0, tx_req = 1'b0, q_alarm = 1'b0, no_free = 1'b0;
  logic tx_grant, jam_en, tx_retry, tx_abort, rx_drop;

  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;
  byte exp_q[$];

  always #4 clk = ~clk;

  hdx_tx_access #(.BIT_CYC(1), .IFG_BITS(IFG), .JAM_BITS(JAM), .SLOT_BITS(SLOT)) u_hdx_tx_access (
    .clk(clk), .rst_n(rst_n), .strap_lim4(strap_lim4), .strap_bp_off(strap_bp_off),
    .full_dup(full_dup), .crs(crs), .col(col), .tx_req(tx_req), .q_alarm(q_alarm),
    .no_free(no_free), .tx_grant(tx_grant), .jam_en(jam_en), .tx_retry(tx_retry),
    .tx_abort(tx_abort), .rx_drop(rx_drop)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  // Scoreboard monitor: every rising output event must match the next expected item.
  logic g_p = 0, j_p = 0, r_p = 0, a_p = 0, d_p = 0;

  task automatic score(input byte got);
    byte want;
    checks++;
    if (exp_q.size() == 0) begin
      errors++;
      $display("FAIL R3 event order: actual=%c expected=none", got);
    end else begin
      want = exp_q.pop_front();
      if (want != got) begin
        errors++;
        $display("FAIL R3 event order: actual=%c expected=%c", got, want);
      end
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (tx_grant && !g_p) score("G");
      if (jam_en   && !j_p) score("J");
      if (tx_retry && !r_p) score("R");
      if (tx_abort && !a_p) score("A");
      if (rx_drop  && !d_p) score("D");
    end
    g_p = tx_grant; j_p = jam_en; r_p = tx_retry; a_p = tx_abort; d_p = rx_drop;
  end

  task automatic do_reset(input bit lim4, input bit bpoff, input bit fd);
    rst_n = 0; strap_lim4 = lim4; strap_bp_off = bpoff; full_dup = fd;
    crs = 0; col = 0; tx_req = 0; q_alarm = 0; no_free = 0;
    repeat (3) step();
    chk({tx_grant, jam_en, tx_retry, tx_abort, rx_drop} == 5'b0, "R9 reset outputs",
        {tx_grant, jam_en, tx_retry, tx_abort, rx_drop}, 0);
    rst_n = 1;
    step();
    strap_lim4 = ~lim4; strap_bp_off = ~bpoff;  // post-reset changes must not matter
    repeat (IFG + 2) step();
  endtask

  task automatic wait_grant(output int n);
    n = 0;
    while (!tx_grant && n < 5000) begin n++; step(); end
  endtask

  // Entered at a negedge where tx_grant==1; collision number n of this frame.
  task automatic collide(input int n, input int cap, input bit last);
    int jl, gap, k, hi;
    exp_q.push_back("J");
    exp_q.push_back(last ? "A" : "R");
    if (!last) exp_q.push_back("G");
    col = 1; step(); col = 0;
    chk(jam_en && !tx_grant, "R2 jam follows collision", {jam_en, tx_grant}, 2'b10);
    jl = 0;
    while (jam_en && jl < 1000) begin jl++; step(); end
    chk(jl == JAM, "R2 jam length", jl, JAM);
    if (last) begin
      chk(tx_abort && !tx_retry, "R5 abort on 16th collision", {tx_abort, tx_retry}, 2'b10);
      tx_req = 0;
      return;
    end
    chk(tx_retry && !tx_abort, "R3 retry pulse", {tx_retry, tx_abort}, 2'b10);
    gap = 0;
    while (!tx_grant && gap < 20000) begin gap++; step(); end
    k  = (n < cap) ? n : cap;
    hi = ((1 << k) - 1) * SLOT + 2;
    if (hi < IFG + 1) hi = IFG + 1;
    if (cap == 4) chk(gap >= IFG + 1 && gap <= hi, "R4 capped backoff window", gap, hi);
    else          chk(gap >= IFG + 1 && gap <= hi, "R3 backoff window", gap, hi);
  endtask

  initial begin
    int n;
    // R1: exact gap after carrier falls, half duplex, back pressure off
    do_reset(0, 1, 0);
    crs = 1; tx_req = 1;
    repeat (30) step();
    chk(!tx_grant, "R1 no grant under carrier", tx_grant, 0);
    exp_q.push_back("G");
    crs = 0;
    for (int j = 1; j <= IFG; j++) begin
      step();
      if (tx_grant) chk(0, "R1 grant too early", j, IFG + 1);
    end
    step();
    chk(tx_grant, "R1 grant at gap+1", tx_grant, 1);
    repeat (5) step();
    tx_req = 0; step();
    chk(!tx_grant, "R10 grant ends after request drops", tx_grant, 0);

    // R2, R3, R4 (cap 10), R10: several collisions then success, then fresh frame
    do_reset(0, 0, 0);
    exp_q.push_back("G");
    tx_req = 1; wait_grant(n);
    for (int c = 1; c <= 6; c++) collide(c, 10, 0);
    tx_req = 0; step();
    chk(!tx_grant, "R10 success clears grant", tx_grant, 0);
    exp_q.push_back("G");
    tx_req = 1; wait_grant(n);
    collide(1, 10, 0);
    tx_req = 0; step();

    // R4 (cap 4) and R5: sixteen collisions lead to abort
    do_reset(1, 0, 0);
    exp_q.push_back("G");
    tx_req = 1; wait_grant(n);
    for (int c = 1; c <= 16; c++) collide(c, 4, c == 16);
    repeat (IFG + 10) step();
    chk(!tx_grant, "R5 no grant after abort without request", tx_grant, 0);
    exp_q.push_back("G");
    tx_req = 1; wait_grant(n);
    collide(1, 4, 0);   // attempt count restarted: k=1 window
    tx_req = 0; step();

    // R6: full duplex ignores carrier and collision
    do_reset(0, 0, 1);
    crs = 1;
    exp_q.push_back("G");
    tx_req = 1; wait_grant(n);
    chk(tx_grant && n <= 2, "R6 grant despite carrier in full duplex", n, 1);
    col = 1; step(); col = 0;
    repeat (3) step();
    chk(tx_grant && !jam_en, "R6 collision ignored", {tx_grant, jam_en}, 2'b10);
    tx_req = 0; crs = 0; step();

    // R7: back pressure jam on incoming frame
    do_reset(0, 0, 0);
    q_alarm = 0; crs = 1;
    repeat (5) step();
    chk(!jam_en, "R7 no jam without alarm", jam_en, 0);
    crs = 0; repeat (3) step();
    q_alarm = 1;
    exp_q.push_back("J");
    crs = 1; step();
    n = 0;
    while (jam_en && n < 100) begin
      if (tx_grant) chk(0, "R7 grant during back pressure jam", 1, 0);
      n++; step();
    end
    chk(n == JAM, "R7 back pressure jam length", n, JAM);
    crs = 0; q_alarm = 0; step();

    // R8: drop instead of jam when back pressure disabled
    do_reset(0, 1, 0);
    q_alarm = 1; no_free = 1;
    exp_q.push_back("D");
    crs = 1; step();
    chk(rx_drop && !jam_en, "R8 drop pulse without jam", {rx_drop, jam_en}, 2'b10);
    step();
    chk(!rx_drop, "R8 drop is one cycle", rx_drop, 0);
    crs = 0; repeat (3) step();

    chk(exp_q.size() == 0, "R3 all expected events seen", exp_q.size(), 0);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule